// File: doc/BRIEF.md
# Reaction-Timing Game Sequencer

This block sequences a reaction-timing game. A four-digit countdown timer starts at 10.00. The player starts it and then tries to stop it as close to 0.00 as possible. The block takes single-cycle pulses from five already-debounced buttons: clear, start/stop, keep, discard and view. It also takes the timer's flag that reports the count has reached its most negative value. From these it produces the following:
- the timer's initialise command and its count enable;
- the commands that save a result into, or empty, the result store;
- the selection of what the display shows;
- a bank of LEDs whose lit count names the display selection.

A modulo-`TICK_DIV` up-counter divides the system clock to make the count enable. With the default of 1,000,000 at 100 MHz, this gives one pulse every 0.01 s. The divider runs only while the game is counting. The game has three phases: ready (timer holds 10.00), running, and stopped (a result is waiting to be kept or discarded).

Top module: `reflex_ctrl`

## Requirements
- R1: While `rst` is high, `tmr_init` is 1, `disp_sel` is 0 and `tmr_en`, `rsp_store` and `rsp_clear` are 0. The first clock edge after release drops `tmr_init`, and the game is ready.
- R2: A `btn_startstop` pulse sampled in the ready phase starts the game. `tmr_en` is then high for exactly one cycle every `TICK_DIV` cycles. The first pulse is in the cycle after the (`TICK_DIV`-1)-th edge following the sampling edge.
- R3: A `btn_startstop` pulse sampled while running stops the game. `tmr_en` then stays low.
- R4: A `btn_keep` pulse sampled while stopped gives one-cycle pulses on `rsp_store` and `tmr_init` after that edge, and returns the game to ready.
- R5: A `btn_discard` pulse sampled while stopped gives a one-cycle `tmr_init` pulse without `rsp_store`, and returns the game to ready. If keep and discard arrive together, keep wins.
- R6: `btn_keep` and `btn_discard` have no effect outside the stopped phase. `btn_startstop` has no effect in the stopped phase.
- R7: A `btn_clear` pulse in any phase gives one-cycle pulses on `rsp_clear` and `tmr_init` after that edge, and returns the game to ready. It overrides every other button sampled in the same cycle.
- R8: Each `btn_view` pulse advances `disp_sel` by one at the sampling edge, wrapping from 3 back to 0. The codes are: 0 running count, 1 last kept result, 2 smallest-magnitude result, 3 largest-magnitude result. Clear does not change `disp_sel`.
- R9: `led` has its `disp_sel`+1 lowest bits set and all higher bits clear.
- R10: If `tmr_min` is high in a running cycle, the game stops at the next edge, and no further `tmr_en` pulse appears.
- R11: The divider restarts from zero on every start, so each run's first `tmr_en` comes a full `TICK_DIV` cycles after its start, whatever happened before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_clear | input | 1 | Clear pulse |
| btn_startstop | input | 1 | Start/stop pulse |
| btn_keep | input | 1 | Keep-result pulse |
| btn_discard | input | 1 | Discard-result pulse |
| btn_view | input | 1 | Advance display selection pulse |
| tmr_min | input | 1 | Timer has reached its most negative value |
| tmr_init | output | 1 | Load 10.00 into the timer |
| tmr_en | output | 1 | One-step count enable for the timer |
| rsp_store | output | 1 | Save the timer value into the result store |
| rsp_clear | output | 1 | Empty the result store |
| disp_sel | output | 2 | Display source code (see R8) |
| led | output | LED_W | Thermometer indication of `disp_sel` |

## Verification
The phase, `disp_sel` and `led` are registered, so a button sampled at one edge shows on these outputs in the cycle that follows it. The three command pulses are registered in the same way and last one cycle. The first `tmr_en` after a start comes `TICK_DIV` cycles after the sampling edge, and later pulses come at the same spacing.

The bench drives inputs on falling edges and reads outputs on the next falling edge. Every comparison is therefore made one cycle after the edge it depends on. For the random part, a cycle model in the bench advances once per edge and predicts the outputs each falling edge must show, including the divider position.

// File: rtl/reflex_pkg.sv
package reflex_pkg;

  typedef enum logic [1:0] {
    GS_READY = 2'd0,
    GS_RUN   = 2'd1,
    GS_STOP  = 2'd2
  } game_st_e;

  // mask with the n lowest bits set
  function automatic logic [31:0] low_mask(input int unsigned n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) m[i] = (i < n);
    return m;
  endfunction

  // wrap-around increment modulo lim
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/reflex_tick.sv
module reflex_tick #(
  parameter int unsigned DIV = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = run && at_last;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (at_last) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/reflex_fsm.sv
module reflex_fsm
  import reflex_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     ss,
  input  logic     keep,
  input  logic     discard,
  input  logic     tmin,
  output game_st_e state,
  output logic     init_q,
  output logic     store_q,
  output logic     clear_q,
  output logic     ev_start,
  output logic     ev_halt,
  output logic     ev_keep,
  output logic     ev_drop
);
  game_st_e st_q, st_d;

  assign ev_start = !clr && (st_q == GS_READY) && ss;
  assign ev_halt  = !clr && (st_q == GS_RUN) && (ss || tmin);
  assign ev_keep  = !clr && (st_q == GS_STOP) && keep;
  assign ev_drop  = !clr && (st_q == GS_STOP) && !keep && discard;

  always_comb begin
    st_d = st_q;
    if (clr)                     st_d = GS_READY;
    else if (ev_start)           st_d = GS_RUN;
    else if (ev_halt)            st_d = GS_STOP;
    else if (ev_keep || ev_drop) st_d = GS_READY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= GS_READY;
      init_q  <= 1'b1;
      store_q <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      init_q  <= clr || ev_keep || ev_drop;
      store_q <= ev_keep;
      clear_q <= clr;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/reflex_mode.sv
module reflex_mode
  import reflex_pkg::*;
#(
  parameter int unsigned NUM_MODES = 4,
  parameter int unsigned LED_W     = 8,
  localparam int unsigned SEL_W    = $clog2(NUM_MODES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [SEL_W-1:0] sel,
  output logic [LED_W-1:0] led
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)      sel_q <= '0;
    else if (adv) sel_q <= SEL_W'(wrap_inc(int'(sel_q), NUM_MODES));
  end

  assign sel = sel_q;
  assign led = LED_W'(low_mask(int'(sel_q) + 1));
endmodule

// File: rtl/reflex_ctrl.sv
module reflex_ctrl
  import reflex_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1_000_000,
  parameter int unsigned LED_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_clear,
  input  logic             btn_startstop,
  input  logic             btn_keep,
  input  logic             btn_discard,
  input  logic             btn_view,
  input  logic             tmr_min,
  output logic             tmr_init,
  output logic             tmr_en,
  output logic             rsp_store,
  output logic             rsp_clear,
  output logic [1:0]       disp_sel,
  output logic [LED_W-1:0] led
);
  localparam int unsigned NUM_MODES = 4;

  game_st_e game_st;
  logic     ev_start, ev_halt, ev_keep, ev_drop;
  logic     running;

  reflex_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .clr     (btn_clear),
    .ss      (btn_startstop),
    .keep    (btn_keep),
    .discard (btn_discard),
    .tmin    (tmr_min),
    .state   (game_st),
    .init_q  (tmr_init),
    .store_q (rsp_store),
    .clear_q (rsp_clear),
    .ev_start(ev_start),
    .ev_halt (ev_halt),
    .ev_keep (ev_keep),
    .ev_drop (ev_drop)
  );

  assign running = (game_st == GS_RUN);

  reflex_tick #(.DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (running),
    .tick(tmr_en)
  );

  reflex_mode #(.NUM_MODES(NUM_MODES), .LED_W(LED_W)) u_mode (
    .clk(clk),
    .rst(rst),
    .adv(btn_view),
    .sel(disp_sel),
    .led(led)
  );
endmodule

// File: rtl/reflex_ctrl_chk.sv
module reflex_ctrl_chk
  import reflex_pkg::*;
#(
  parameter int unsigned LED_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             btn_clear,
  input logic             btn_startstop,
  input logic             btn_keep,
  input logic             btn_discard,
  input logic             btn_view,
  input logic             tmr_min,
  input logic             tmr_init,
  input logic             tmr_en,
  input logic             rsp_store,
  input logic             rsp_clear,
  input logic [1:0]       disp_sel,
  input logic [LED_W-1:0] led,
  input game_st_e         game_st
);
  a_r2_tick_only_running: assert property (@(posedge clk) disable iff (rst)
    tmr_en |-> game_st == GS_RUN);

  a_r3_start_ignored_stopped: assert property (@(posedge clk) disable iff (rst)
    (game_st == GS_STOP && !btn_clear && !btn_keep && !btn_discard) |=> game_st == GS_STOP);

  a_r4_store_from_stop: assert property (@(posedge clk) disable iff (rst)
    rsp_store |-> $past(game_st) == GS_STOP);

  a_r6_no_store_outside_stop: assert property (@(posedge clk) disable iff (rst)
    (game_st != GS_STOP) |=> !rsp_store);

  a_r7_clear_reinit: assert property (@(posedge clk) disable iff (rst)
    btn_clear |=> (tmr_init && rsp_clear && game_st == GS_READY));

  a_r8_mode_advance: assert property (@(posedge clk) disable iff (rst)
    btn_view |=> disp_sel == (($past(disp_sel) == 2'd3) ? 2'd0 : $past(disp_sel) + 2'd1));

  a_r9_led_count: assert property (@(posedge clk) disable iff (rst)
    ($countones(led) == int'(disp_sel) + 1) && led[0]);

  a_r10_min_halts: assert property (@(posedge clk) disable iff (rst)
    (game_st == GS_RUN && tmr_min && !btn_clear) |=> game_st == GS_STOP);
endmodule

bind reflex_ctrl reflex_ctrl_chk #(.LED_W(LED_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .btn_clear    (btn_clear),
  .btn_startstop(btn_startstop),
  .btn_keep     (btn_keep),
  .btn_discard  (btn_discard),
  .btn_view     (btn_view),
  .tmr_min      (tmr_min),
  .tmr_init     (tmr_init),
  .tmr_en       (tmr_en),
  .rsp_store    (rsp_store),
  .rsp_clear    (rsp_clear),
  .disp_sel     (disp_sel),
  .led          (led),
  .game_st      (game_st)
);

// File: tb/reflex_ctrl_tb.sv
module reflex_ctrl_tb;
  localparam int unsigned N = 6;
  localparam int unsigned LW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic b_clr = 0, b_ss = 0, b_keep = 0, b_disc = 0, b_view = 0, t_min = 0;
  logic tmr_init, tmr_en, rsp_store, rsp_clear;
  logic [1:0] disp_sel;
  logic [LW-1:0] led;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reflex_ctrl #(.TICK_DIV(N), .LED_W(LW)) u_dut (
    .clk(clk), .rst(rst), .btn_clear(b_clr), .btn_startstop(b_ss),
    .btn_keep(b_keep), .btn_discard(b_disc), .btn_view(b_view), .tmr_min(t_min),
    .tmr_init(tmr_init), .tmr_en(tmr_en), .rsp_store(rsp_store), .rsp_clear(rsp_clear),
    .disp_sel(disp_sel), .led(led)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] exp_led(input int m);
    logic [LW-1:0] v = '0;
    for (int i = 0; i <= m; i++) v = {v[LW-2:0], 1'b1};
    return v;
  endfunction

  // buttons {clear, startstop, keep, discard, view}
  task automatic press(input logic [4:0] b, input logic mn = 1'b0);
    {b_clr, b_ss, b_keep, b_disc, b_view} = b;
    t_min = mn;
    @(negedge clk);
    {b_clr, b_ss, b_keep, b_disc, b_view} = '0;
    t_min = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expects first tick at offset N-1 from the current falling edge
  task automatic check_ticks(input string tag, input int periods);
    for (int i = 0; i < periods * N; i++) begin
      chk(tag, tmr_en, ((i % N) == N - 1));
      @(negedge clk);
    end
  endtask

  task automatic check_quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      chk(tag, tmr_en, 0);
      @(negedge clk);
    end
  endtask

  // bench cycle model
  int ms, mc, mm;
  logic e_init, e_store, e_clr;

  task automatic model_step(input logic [4:0] b, input logic mn);
    int old = ms;
    e_init = 0; e_store = 0; e_clr = 0;
    if (b[4]) begin ms = 0; e_clr = 1; e_init = 1; end
    else if (ms == 0 && b[3]) ms = 1;
    else if (ms == 1 && (b[3] || mn)) ms = 2;
    else if (ms == 2 && b[2]) begin ms = 0; e_store = 1; e_init = 1; end
    else if (ms == 2 && b[1]) begin ms = 0; e_init = 1; end
    mc = (old == 1) ? ((mc == N - 1) ? 0 : mc + 1) : 0;
    if (b[0]) mm = (mm + 1) % 4;
  endtask

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    chk("R1 init in reset", tmr_init, 1);
    chk("R1 sel in reset", disp_sel, 0);
    chk("R1 pulses in reset", {tmr_en, rsp_store, rsp_clear}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 init drops", tmr_init, 0);
    chk("R9 led reset", led, exp_led(0));

    press(5'b00100);
    chk("R6 keep in ready", {rsp_store, tmr_init}, 0);
    press(5'b00010);
    chk("R6 discard in ready", tmr_init, 0);

    press(5'b01000);
    check_ticks("R2 tick spacing", 2);
    press(5'b01000);
    check_quiet("R3 halted", 2 * N);
    press(5'b01000);
    check_quiet("R6 startstop in stop", N);
    press(5'b00010);
    chk("R5 discard init", tmr_init, 1);
    chk("R5 discard no store", rsp_store, 0);

    press(5'b01000);
    idle(3);
    press(5'b10000);
    chk("R7 clear pulse", {rsp_clear, tmr_init}, 2'b11);
    press(5'b01000);
    check_ticks("R11 divider restart", 1);

    press(5'b00100);
    chk("R6 keep while running", rsp_store, 0);
    press(5'b01000);
    press(5'b00100);
    chk("R4 keep pulses", {rsp_store, tmr_init}, 2'b11);
    @(negedge clk);
    chk("R4 one cycle", {rsp_store, tmr_init}, 0);

    press(5'b01000);
    idle(2);
    press(5'b00000, 1'b1);
    check_quiet("R10 min halts", 2 * N);
    press(5'b00110);
    chk("R5 keep beats discard", rsp_store, 1);

    press(5'b01000);
    press(5'b01000);
    press(5'b10100);
    chk("R7 clear overrides keep", {rsp_clear, rsp_store, tmr_init}, 3'b101);

    for (int k = 1; k <= 5; k++) begin
      press(5'b00001);
      chk("R8 view advance", disp_sel, k % 4);
      chk("R9 led mode", led, exp_led(k % 4));
    end
    press(5'b10000);
    chk("R8 clear keeps sel", disp_sel, 1);

    // random phase against bench model
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    ms = 0; mc = 0; mm = 0; e_init = 0; e_store = 0; e_clr = 0;
    for (int c = 0; c < 3000; c++) begin
      logic [4:0] b;
      logic mn;
      chk("R2 rnd tick", tmr_en, (ms == 1) && (mc == N - 1));
      chk("R4 rnd store", rsp_store, e_store);
      chk("R7 rnd clear", rsp_clear, e_clr);
      chk("R5 rnd init", tmr_init, e_init);
      chk("R8 rnd sel", disp_sel, mm);
      chk("R9 rnd led", led, exp_led(mm));
      b[4] = ($urandom % 40) == 0;
      b[3] = ($urandom % 12) == 0;
      b[2] = ($urandom % 10) == 0;
      b[1] = ($urandom % 10) == 0;
      b[0] = ($urandom % 8) == 0;
      mn   = ($urandom % 30) == 0;
      model_step(b, mn);
      press(b, mn);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule